// File: doc/BRIEF.md
# Serial Frame Clock-Count Validator

This block sits behind the front end of a three-wire serial memory interface. It counts rising edges of the serial clock from the cycle in which the start bit is recognised up to the falling edge of chip select. When chip select falls, it compares the count with the exact frame length that the decoded instruction needs. For an instruction that modifies stored contents, it then emits a one-cycle commit pulse if the lengths match, or a one-cycle abort pulse if they do not.

The commit pulse is the only event that may launch the self-timed programming cycle. A noise glitch that adds a clock, a dropped clock, or a chip-select release one slot early or late therefore leaves the memory untouched. All inputs are single-cycle strobes that have already been synchronised to the system clock. The instruction class comes from an external decoder and must be held stable until chip select falls. The running count is brought out for debug.

Top module: `frame_len_checker`

## Requirements
- R1: After reset, `edge_count` is 0 and `commit` and `abort` are both low.
- R2: In a cycle where `start_seen` is high, the count is loaded with 1, because the edge that sampled the start bit counts, and the frame becomes open.
- R3: While a frame is open, each `clk_rise` cycle with no `sel_fall` raises `edge_count` by one.
- R4: The count saturates at 2^COUNT_W-1 (127 by default) and never wraps.
- R5: Class 1 (single-word write) and class 3 (write-all) commit only when the count is exactly 27 at the chip-select fall.
- R6: Class 2 (page write) commits only when the count is 27, 43, 59 or 75, which is one to four 16-bit words after an 11-clock header.
- R7: Class 4 (protection write) and class 5 (protection clear) commit only when the count is exactly 11.
- R8: A modifying class (1 to 5) whose count does not match raises `abort` instead. Either pulse is high for one cycle, in the cycle after the `sel_fall` strobe.
- R9: Classes 0, 6 and 7 are non-modifying and never produce `commit` or `abort`.
- R10: With no frame open, `clk_rise` and `sel_fall` are ignored: the count holds and no pulse is issued.
- R11: `commit` and `abort` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_rise | input | 1 | Strobe for a synchronised serial-clock rising edge |
| sel_fall | input | 1 | Strobe for a synchronised chip-select falling edge |
| start_seen | input | 1 | Strobe for the start bit, given in the same cycle as its clock edge |
| op_class | input | 3 | Decoded instruction class, held until chip select falls |
| commit | output | 1 | One-cycle pulse: a modifying frame had the correct length |
| abort | output | 1 | One-cycle pulse: a modifying frame had the wrong length |
| edge_count | output | COUNT_W | Current edge count, for debug |

## Verification
A corrupted count shows up on `edge_count` at the next sampled cycle. The same fault moves the outcome to the opposite pulse one cycle after the chip-select strobe, so frames one clock short of, exactly at, and one clock past each valid length expose it right away. A stale open-frame flag shows up as a pulse after a stray chip-select fall, or as the count moving while idle. A wrong saturation limit is visible after a frame longer than the counter can hold.

// File: rtl/frame_len_checker.sv
module frame_len_checker #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int OPC_W      = 2,
  parameter int PAGE_WORDS = 4,
  parameter int COUNT_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_rise,
  input  logic               sel_fall,
  input  logic               start_seen,
  input  logic [2:0]         op_class,
  output logic               commit,
  output logic               abort,
  output logic [COUNT_W-1:0] edge_count
);
  localparam int HDR_LEN  = 1 + OPC_W + ADDR_W;
  localparam int WORD_LEN = HDR_LEN + DATA_W;
  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  localparam logic [2:0] CL_WORD = 3'd1;
  localparam logic [2:0] CL_PAGE = 3'd2;
  localparam logic [2:0] CL_ALL  = 3'd3;
  localparam logic [2:0] CL_PWR  = 3'd4;
  localparam logic [2:0] CL_PCLR = 3'd5;

  logic armed;
  logic [PAGE_WORDS-1:0] page_hit;

  for (genvar k = 0; k < PAGE_WORDS; k++) begin : g_page
    assign page_hit[k] = (edge_count == COUNT_W'(HDR_LEN + (k + 1) * DATA_W));
  end

  wire word_ok = (edge_count == COUNT_W'(WORD_LEN));
  wire hdr_ok  = (edge_count == COUNT_W'(HDR_LEN));
  wire is_mod  = (op_class >= CL_WORD) && (op_class <= CL_PCLR);

  logic len_ok;
  always_comb begin
    case (op_class)
      CL_WORD, CL_ALL: len_ok = word_ok;
      CL_PAGE:         len_ok = |page_hit;
      CL_PWR, CL_PCLR: len_ok = hdr_ok;
      default:         len_ok = 1'b0;
    endcase
  end

  wire close_now = armed && sel_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      edge_count <= '0;
      commit     <= 1'b0;
      abort      <= 1'b0;
    end else begin
      commit <= close_now && is_mod && len_ok;
      abort  <= close_now && is_mod && !len_ok;
      if (close_now) begin
        armed <= 1'b0;
      end else if (start_seen) begin
        armed      <= 1'b1;
        edge_count <= COUNT_W'(1);
      end else if (armed && clk_rise && edge_count != CNT_MAX) begin
        edge_count <= edge_count + 1'b1;
      end
    end
  end

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));
  assert_commit_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  assert_abort_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  assert_only_mod_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> ($past(sel_fall) && $past(is_mod)));
  assert_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clk_rise && !sel_fall && !start_seen && edge_count == CNT_MAX)
      |=> edge_count == CNT_MAX);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clk_rise && !sel_fall && !start_seen && edge_count != CNT_MAX)
      |=> edge_count == $past(edge_count) + 1'b1);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start_seen) |=> ($stable(edge_count) && !commit && !abort));
endmodule

// File: tb/tb_frame_len_checker.sv
module tb_frame_len_checker;
  localparam int CW = 7;
  localparam int MAXC = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_rise = 1'b0, sel_fall = 1'b0, start_seen = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic commit, abort;
  logic [CW-1:0] edge_count;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  integer m_cnt = 0;
  bit m_armed = 0, m_commit = 0, m_abort = 0;

  frame_len_checker dut (
    .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .sel_fall(sel_fall),
    .start_seen(start_seen), .op_class(op_class), .commit(commit),
    .abort(abort), .edge_count(edge_count));

  always #5 clk = ~clk;

  function automatic bit model_ok(input int cls, input int n);
    case (cls)
      1, 3: return n == 27;
      2: return n == 27 || n == 43 || n == 59 || n == 75;
      4, 5: return n == 11;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_commit = 0; m_abort = 0;
    end else begin
      m_commit = 0; m_abort = 0;
      if (m_armed && sel_fall) begin
        if (op_class >= 1 && op_class <= 5) begin
          m_commit = model_ok(op_class, m_cnt);
          m_abort = !m_commit;
        end
        m_armed = 0;
      end else if (start_seen) begin
        m_cnt = 1; m_armed = 1;
      end else if (m_armed && clk_rise && m_cnt < MAXC) begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check(cur_req, edge_count, m_cnt, "edge_count vs model");
    check(cur_req, {commit, abort}, {m_commit, m_abort}, "commit/abort vs model");
    if (cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input bit s, input bit r, input bit f);
    start_seen = s; clk_rise = r; sel_fall = f;
    @(negedge clk);
    start_seen = 0; clk_rise = 0; sel_fall = 0;
  endtask

  task automatic frame(input string req, input int cls, input int n, input int exp_c, input int exp_a);
    int c_seen;
    int a_seen;
    cur_req = req;
    op_class = 3'(cls);
    step(1, 1, 0);
    if (req == "R2") check("R2", edge_count, 1, "count after start");
    for (int i = 1; i < n; i++) begin
      step(0, 0, 0);
      step(0, 1, 0);
    end
    step(0, 0, 0);
    check("R3", edge_count, (n > MAXC) ? MAXC : n, "count before fall");
    step(0, 0, 1);
    c_seen = commit; a_seen = abort;
    check(req, c_seen, exp_c, $sformatf("commit cls=%0d n=%0d", cls, n));
    check(req, a_seen, exp_a, $sformatf("abort cls=%0d n=%0d", cls, n));
    step(0, 0, 0);
    check("R8", {commit, abort}, 0, "pulse width one cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", edge_count, 0, "reset count");
    check("R1", {commit, abort}, 0, "reset pulses");
    rst_n = 1;
    @(negedge clk);
    frame("R2", 1, 27, 1, 0);
    frame("R5", 1, 26, 0, 1);
    frame("R5", 1, 28, 0, 1);
    frame("R5", 3, 27, 1, 0);
    frame("R8", 3, 11, 0, 1);
    frame("R6", 2, 27, 1, 0);
    frame("R6", 2, 43, 1, 0);
    frame("R6", 2, 59, 1, 0);
    frame("R6", 2, 75, 1, 0);
    frame("R6", 2, 35, 0, 1);
    frame("R6", 2, 91, 0, 1);
    frame("R7", 4, 11, 1, 0);
    frame("R7", 4, 12, 0, 1);
    frame("R7", 5, 11, 1, 0);
    frame("R7", 5, 10, 0, 1);
    frame("R9", 0, 27, 0, 0);
    frame("R9", 6, 11, 0, 0);
    frame("R9", 7, 27, 0, 0);
    frame("R4", 1, 130, 0, 1);
    cur_req = "R10";
    op_class = 3'd1;
    for (int i = 0; i < 5; i++) step(0, 1, 0);
    check("R10", edge_count, MAXC, "idle edges ignored");
    step(0, 0, 1);
    check("R10", {commit, abort}, 0, "stray fall ignored");
    step(0, 0, 0);
    frame("R11", 1, 27, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule